// File: doc/BRIEF.md
# Stochastic Bayesian Network Evaluator

This block estimates the marginal probability of one or two child events in a small Bayesian network. It does so with stochastic computing: every probability is a bit-stream in which the fraction of ones is the value. Each prior and each conditional-table entry is loaded as an 8-bit threshold. Each threshold drives its own random-bit generator, so that every stream is independent of the others. Multiplexers pick a table stream per cycle, steered by the parent streams, and an output counter totals the child's ones over a run of programmable length.

A run begins with a start pulse while the block is idle. The block captures the shape, the thresholds and the length, reloads every generator seed and clears the counts. It then stays busy for exactly the run length and raises a one-cycle done pulse with the final counts. Three network shapes are supported: one parent with one child, two parents with one child, and one parent with two children. The controller is a three-state machine. In S_IDLE, a start pulse moves it to S_RUN. S_RUN stays in place while more than one cycle remains and moves to S_DONE on its last cycle. S_DONE always returns to S_IDLE after one cycle.

Top module: `sbn_eval`

## Requirements
- R1: A start pulse sampled in S_IDLE captures shape, thresholds and length, reloads all seeds and clears both counts. A start pulse sampled while busy or done is ignored.
- R2: busy is high for exactly L consecutive cycles, beginning in the cycle after the start edge. L is the length input, or 200 when that input is 0.
- R3: done is high for exactly one cycle, immediately after busy falls. Both counts are final in that cycle and are held until the next accepted start.
- R4: Each generator emits 1 when the low 8 bits of its shift register are below its threshold. Threshold 0 therefore never gives a 1, and threshold 255 gives a 1 except when the low byte is 255.
- R5: Shape code 0 (and the spare code 3) is a single child. Slot 0 is the parent A, and child 0 is slot 2 when A is 1 and slot 3 when A is 0. count1 stays 0.
- R6: Shape code 1 is two parents. Slot 0 is A1 and slot 1 is A2. Child 0 is slot 2+{A1,A2}, where the index is A1·2+A2. count1 stays 0.
- R7: Shape code 2 is two children. Child 0 is A ? slot 2 : slot 3, and child 1 is A ? slot 4 : slot 5, with A from slot 0.
- R8: Each count is within 3·sqrt(L)+4 of L times the analytic probability, taking each slot's probability as threshold/256. A threshold slot k sits at thr bits [8k+7:8k].
- R9: Two runs with the same configuration give identical counts. Changes to any input other than rst_n during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| mode | input | 2 | Network shape code |
| len | input | 16 | Run length in cycles; 0 selects 200 |
| thr | input | 48 | Six 8-bit thresholds, slot k at [8k+7:8k] |
| busy | output | 1 | High during the counting cycles |
| done | output | 1 | One-cycle completion pulse |
| count0 | output | 16 | Ones counted at child 0 |
| count1 | output | 16 | Ones counted at child 1 |

## Verification
Once the start edge is sampled, busy is due one cycle later. The bench sets its inputs at a falling edge and reads busy at each following falling edge. It counts busy cycles until busy drops, checks done in that same sample and checks that done has cleared one sample later. The counts are read during done and again one cycle later to confirm that they hold. The sweeps cover each shape over many threshold sets, including the exact-zero and near-one extremes. In the disturbed runs, start, shape, length and thresholds are changed in mid-run, and the counts must match an undisturbed run.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

    localparam int NUM_GEN   = 6;
    localparam int NUM_CHILD = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_PAIR   = 2'd1,
        MODE_FANOUT = 2'd2,
        MODE_SPARE  = 2'd3
    } sbn_mode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } sbn_state_t;

    // Two-tap maximal-length feedback pairs, one distinct pair per generator.
    function automatic int gen_width(input int idx);
        case (idx)
            0:       return 17;
            1:       return 18;
            2:       return 20;
            3:       return 21;
            4:       return 22;
            default: return 23;
        endcase
    endfunction

    function automatic int gen_tap(input int idx);
        case (idx)
            0:       return 14;
            1:       return 11;
            2:       return 17;
            3:       return 19;
            4:       return 21;
            default: return 18;
        endcase
    endfunction

    function automatic logic [31:0] gen_seed(input int idx);
        logic [31:0] mix;
        mix = (32'h0005_A5A3 * (idx + 1)) ^ 32'h0001_F00D;
        return mix | 32'd1;
    endfunction

endpackage

// File: rtl/sbn_sbitgen.sv
module sbn_sbitgen #(
    parameter int LFSR_W = 17,
    parameter int TAP    = 14,
    parameter int TH_W   = 8,
    parameter logic [LFSR_W-1:0] SEED = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [TH_W-1:0] thr,
    output logic            bit_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_adv;

    // Advance TH_W positions per cycle so the compared byte is fresh each cycle.
    always_comb begin
        lfsr_adv = lfsr_q;
        for (int k = 0; k < TH_W; k++) begin
            lfsr_adv = {lfsr_adv[LFSR_W-2:0], lfsr_adv[LFSR_W-1] ^ lfsr_adv[TAP-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (load) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= lfsr_adv;
        end
    end

    assign bit_o = (lfsr_q[TH_W-1:0] < thr);

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R4
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |-> !bit_o);

endmodule

// File: rtl/sbn_select.sv
module sbn_select
    import sbn_pkg::*;
(
    input  logic [NUM_GEN-1:0]   bits,
    input  sbn_mode_t            mode,
    output logic [NUM_CHILD-1:0] child
);

    logic [1:0] pair_idx;

    always_comb begin
        pair_idx = {bits[0], bits[1]};
        child    = '0;
        unique case (mode)
            MODE_SINGLE, MODE_SPARE: begin
                child[0] = bits[0] ? bits[2] : bits[3];
            end
            MODE_PAIR: begin
                unique case (pair_idx)
                    2'd0: child[0] = bits[2];
                    2'd1: child[0] = bits[3];
                    2'd2: child[0] = bits[4];
                    2'd3: child[0] = bits[5];
                    default: child[0] = 1'b0;
                endcase
            end
            MODE_FANOUT: begin
                child[0] = bits[0] ? bits[2] : bits[3];
                child[1] = bits[0] ? bits[4] : bits[5];
            end
            default: child = '0;
        endcase
    end

endmodule

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
    import sbn_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int DEF_LEN = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    output logic             busy,
    output logic             done,
    output logic             load
);

    localparam logic [LEN_W-1:0] DEF_LEN_V = LEN_W'(DEF_LEN);

    sbn_state_t       state_q, state_d;
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (rem_q == LEN_W'(1)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        unique case (state_q)
            S_IDLE:  load = start;
            S_RUN:   busy = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= (len_in == '0) ? DEF_LEN_V : len_in;
        end else if (busy) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    // R2
    rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q != '0));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rem_q > LEN_W'(1)) |=> busy);

    // R3
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

// File: rtl/sbn_tally.sv
module sbn_tally #(
    parameter int CNT_W = 16,
    parameter int N     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      step,
    input  logic [N-1:0]              bits,
    output logic [N-1:0][CNT_W-1:0]   counts
);

    for (genvar c = 0; c < N; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                counts[c] <= '0;
            end else if (clear) begin
                counts[c] <= '0;
            end else if (step && bits[c]) begin
                counts[c] <= counts[c] + CNT_W'(1);
            end
        end

        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!step && !clear) |=> $stable(counts[c]));
    end

endmodule

// File: rtl/sbn_eval.sv
module sbn_eval
    import sbn_pkg::*;
#(
    parameter int TH_W    = 8,
    parameter int CNT_W   = 16,
    parameter int DEF_LEN = 200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              mode,
    input  logic [CNT_W-1:0]        len,
    input  logic [NUM_GEN*TH_W-1:0] thr,
    output logic                    busy,
    output logic                    done,
    output logic [CNT_W-1:0]        count0,
    output logic [CNT_W-1:0]        count1
);

    logic                            load;
    sbn_mode_t                       mode_q;
    logic [TH_W-1:0]                 thr_q [NUM_GEN];
    logic [NUM_GEN-1:0]              gen_bits;
    logic [NUM_CHILD-1:0]            child;
    logic [NUM_CHILD-1:0][CNT_W-1:0] counts;

    sbn_ctrl #(.LEN_W(CNT_W), .DEF_LEN(DEF_LEN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len_in (len),
        .busy   (busy),
        .done   (done),
        .load   (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SINGLE;
        end else if (load) begin
            mode_q <= sbn_mode_t'(mode);
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam int          W   = gen_width(g);
        localparam int          T   = gen_tap(g);
        localparam logic [31:0] SD  = gen_seed(g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[g] <= '0;
            end else if (load) begin
                thr_q[g] <= thr[g*TH_W +: TH_W];
            end
        end

        sbn_sbitgen #(.LFSR_W(W), .TAP(T), .TH_W(TH_W), .SEED(SD[W-1:0])) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (busy),
            .thr   (thr_q[g]),
            .bit_o (gen_bits[g])
        );
    end

    sbn_select u_sel (
        .bits  (gen_bits),
        .mode  (mode_q),
        .child (child)
    );

    sbn_tally #(.CNT_W(CNT_W), .N(NUM_CHILD)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .step   (busy),
        .bits   (child),
        .counts (counts)
    );

    assign count0 = counts[0];
    assign count1 = counts[1];

    // R5 R6
    single_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q != MODE_FANOUT) |-> (count1 == '0));

    // R9
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $stable(mode_q));

endmodule

// File: tb/sbn_eval_test.sv
`timescale 1ns/100ps
module sbn_eval_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] len = 16'd0;
    logic [47:0] thr = '0;
    logic        busy, done;
    logic [15:0] count0, count1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] th [6];

    always #2.5 clk = ~clk;

    sbn_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len(len),
        .thr(thr), .busy(busy), .done(done), .count0(count0), .count1(count1)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [47:0] pack_thr();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[k*8 +: 8] = th[k];
        return v;
    endfunction

    function automatic real pr(input int k);
        return real'(th[k]) / 256.0;
    endfunction

    function automatic real expect_p(input logic [1:0] m, input int child);
        real a1, a2, s;
        a1 = pr(0);
        a2 = pr(1);
        if (m == 2'd1) begin
            if (child == 1) return 0.0;
            s = (1.0 - a1) * (1.0 - a2) * pr(2) + (1.0 - a1) * a2 * pr(3)
              + a1 * (1.0 - a2) * pr(4) + a1 * a2 * pr(5);
            return s;
        end
        if (m == 2'd2) begin
            if (child == 1) return a1 * pr(4) + (1.0 - a1) * pr(5);
            return a1 * pr(2) + (1.0 - a1) * pr(3);
        end
        if (child == 1) return 0.0;
        return a1 * pr(2) + (1.0 - a1) * pr(3);
    endfunction

    // One run. Inputs are set at a falling edge; busy is sampled at every later falling edge.
    task automatic do_run(input logic [1:0] m, input int l, input bit disturb,
                          output int c0, output int c1, output int nbusy,
                          output bit done_ok, output bit held_ok);
        mode  = m;
        len   = l[15:0];
        thr   = pack_thr();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nbusy = 0;
        while (busy && nbusy < 70000) begin
            nbusy++;
            if (disturb && nbusy == 3) begin
                start = 1'b1;
                thr   = ~thr;
                mode  = ~m;
                len   = 16'd7;
            end else if (disturb && nbusy == 4) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start   = 1'b0;
        done_ok = done;
        c0      = count0;
        c1      = count1;
        @(negedge clk);
        done_ok = done_ok && !done;
        held_ok = (count0 == c0[15:0]) && (count1 == c1[15:0]) && !busy;
    endtask

    task automatic stat_run(input logic [1:0] m, input int l, input string req);
        int c0, c1, nb, lexp, e0, e1, tol;
        bit dok, hok;
        do_run(m, l, 1'b0, c0, c1, nb, dok, hok);
        lexp = (l == 0) ? 200 : l;
        tol  = $rtoi(3.0 * $sqrt(real'(lexp))) + 4;
        e0   = $rtoi(expect_p(m, 0) * real'(lexp) + 0.5);
        e1   = $rtoi(expect_p(m, 1) * real'(lexp) + 0.5);
        chk(nb == lexp, "R2 busy length", nb, lexp);
        chk(dok, "R3 done single pulse", int'(dok), 1);
        chk(hok, "R3 counts held after done", int'(hok), 1);
        chk((c0 - e0 <= tol) && (e0 - c0 <= tol), {req, " R8 count0"}, c0, e0);
        chk((c1 - e1 <= tol) && (e1 - c1 <= tol), {req, " R8 count1"}, c1, e1);
        if (m != 2'd2) chk(c1 == 0, {req, " count1 zero"}, c1, 0);
    endtask

    initial begin
        int c0, c1, nb, r0, r1;
        bit dok, hok;
        int pa_set [5];
        int pb_set [3][2];
        pa_set = '{0, 64, 128, 192, 255};
        pb_set = '{'{255, 0}, '{0, 255}, '{128, 200}};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!busy && !done, "R2 reset idle", int'(busy) + int'(done), 0);
        chk(count0 == 0 && count1 == 0, "R1 reset counts", int'(count0) + int'(count1), 0);

        // Reference case, default length via len=0
        th = '{8'd72, 8'd0, 8'd128, 8'd143, 8'd0, 8'd0};
        stat_run(2'd0, 0, "R5 reference");

        // R5 sweep: single child
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 3; j++) begin
                th = '{pa_set[i][7:0], 8'd0, pb_set[j][0][7:0], pb_set[j][1][7:0], 8'd0, 8'd0};
                stat_run(2'd0, 2000, "R5 single sweep");
            end
        end
        // Spare code behaves as single child
        th = '{8'd90, 8'd0, 8'd230, 8'd20, 8'd0, 8'd0};
        stat_run(2'd3, 2000, "R5 spare code");

        // R6: exact slot selection with extreme parents, then mixed tables
        for (int s = 0; s < 4; s++) begin
            th = '{(s >= 2) ? 8'd255 : 8'd0, (s % 2 == 1) ? 8'd255 : 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
            th[2 + s] = 8'd255;
            stat_run(2'd1, 2000, "R6 slot select");
        end
        th = '{8'd100, 8'd180, 8'd20, 8'd240, 8'd130, 8'd60};
        stat_run(2'd1, 2000, "R6 mixed");
        th = '{8'd200, 8'd40, 8'd255, 8'd0, 8'd10, 8'd170};
        stat_run(2'd1, 2000, "R6 mixed");

        // R7: two children
        th = '{8'd255, 8'd0, 8'd255, 8'd0, 8'd0, 8'd255};
        stat_run(2'd2, 2000, "R7 parent high");
        th = '{8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd255};
        stat_run(2'd2, 2000, "R7 parent low");
        th = '{8'd150, 8'd0, 8'd50, 8'd220, 8'd190, 8'd30};
        stat_run(2'd2, 2000, "R7 mixed");

        // R4: all-zero thresholds give exactly zero, all-max gives almost all ones
        th = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
        do_run(2'd2, 1000, 1'b0, c0, c1, nb, dok, hok);
        chk(c0 == 0 && c1 == 0, "R4 zero threshold", c0 + c1, 0);
        th = '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255};
        do_run(2'd2, 1000, 1'b0, c0, c1, nb, dok, hok);
        chk(c0 >= 975 && c0 <= 1000, "R4 max threshold child0", c0, 996);
        chk(c1 >= 975 && c1 <= 1000, "R4 max threshold child1", c1, 996);

        // R9: repeatability and immunity to mid-run input changes; R1 start ignored
        th = '{8'd72, 8'd30, 8'd128, 8'd143, 8'd210, 8'd15};
        do_run(2'd2, 300, 1'b0, r0, r1, nb, dok, hok);
        do_run(2'd2, 300, 1'b0, c0, c1, nb, dok, hok);
        chk(c0 == r0 && c1 == r1, "R9 repeat run", c0 * 65536 + c1, r0 * 65536 + r1);
        do_run(2'd2, 300, 1'b1, c0, c1, nb, dok, hok);
        chk(nb == 300, "R1 start during busy ignored", nb, 300);
        chk(c0 == r0 && c1 == r1, "R9 disturbed run", c0 * 65536 + c1, r0 * 65536 + r1);

        // R1: an accepted start clears counts before counting; length 1 boundary
        th = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
        do_run(2'd0, 1, 1'b0, c0, c1, nb, dok, hok);
        chk(c0 == 0 && c1 == 0, "R1 counts cleared", c0 + c1, 0);
        chk(nb == 1, "R2 length one", nb, 1);
        chk(dok, "R3 done after length one", int'(dok), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule